// File: doc/BRIEF.md
# Field Memory Power-Up Sequencer

This block runs on the host side of a serial field memory and brings that memory from power-up into a state where it can stream. It has two ports, and the write clocks and the read clocks are shared between them. The block does not generate the memory clocks. It drives a write-clock gate, a read-clock gate, and per-port write-reset and read-reset strobes. It raises `done` once the memory is ready.

After a `start` request the block first waits until the supply has been reported good for an unbroken interval. It then runs the memory clocks for a number of dummy cycles and strobes every reset on both sides in the same cycle. A guard window follows each strobe. In that window the memory clocks keep running with every reset low, so two strobes on one port are always spaced apart.

If the supply-good input dropped while the dummy cycles or the first reset were running, the block does not finish there. It runs a recovery pass instead: a reset, a full set of clock cycles, and a further reset, each reset with its own guard window. All intervals are given as parameters in system-clock cycles.

Top module: `fmem_init_seq`

## Requirements
- R1: While `rst` is high and afterwards until `start` is seen, every output is low, whatever `supply_ok` does.
- R2: The first rising edge that samples `start` high puts the block into the wait phase. In this phase every output is low, and the phase lasts exactly `STABLE_CYC` cycles when `supply_ok` stays high.
- R3: An edge that samples `supply_ok` low during the wait phase restarts the wait count from zero. The phase then lasts a further `STABLE_CYC` cycles from that edge.
- R4: After the wait phase, `mem_wclk_en` and `mem_rclk_en` are both high and all resets are low for exactly `DUMMY_CYC` cycles.
- R5: A reset strobe lasts one cycle. In that cycle every bit of `mem_wrst` and `mem_rrst` is high together, and both clock gates are high.
- R6: Every strobe is followed by exactly `RST_GAP` cycles with both clock gates high and all resets low. No strobe ever occurs in the cycle after a strobe or two cycles after one.
- R7: After the last guard window, `done` is high and the clock gates and resets are low. This holds until the next `start`.
- R8: If `supply_ok` is sampled low during the dummy cycles or the first strobe window, the block runs a recovery pass before `done`. The pass is a strobe plus guard window, then `DUMMY_CYC` clock cycles, then a strobe plus guard window.
- R9: `start` in any state restarts the wait phase on the next edge. It drops `done` and the clock gates, and it clears the recorded supply drop.
- R10: `done` is never high in a cycle where a clock gate or reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart request, sampled each rising edge |
| supply_ok | input | 1 | High when the memory supply is reported stable |
| mem_wclk_en | output | 1 | Gate for the shared memory write clock |
| mem_rclk_en | output | 1 | Gate for the shared memory read clock |
| mem_wrst | output | NPORT | Write-reset strobe, one bit per port |
| mem_rrst | output | NPORT | Read-reset strobe, one bit per port |
| done | output | 1 | Memory initialised and ready |

## Verification
The checker assumes `start` is a synchronous single-cycle request, and it allows a restart to break any phase short. It also assumes `supply_ok` may change freely between edges. The checker relies only on ordering: strobes are spaced, the first strobe after the clocks come on is preceded by at least the dummy count, and `done` stays quiet. The bench drives `start` for exactly one cycle at a time. It changes `supply_ok` only at falling edges, and it places each drop on a chosen edge: inside the wait phase, inside the dummy phase, or just before a restart. This lets the expected cycle stream be written down ahead of time.

// File: rtl/fmem_init_pkg.sv
package fmem_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DUMMY,
        ST_RESET,
        ST_RREC1,
        ST_RCYC,
        ST_RREC2,
        ST_DONE
    } seq_state_e;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Memory clocks run in every phase between the wait and done
    function automatic logic clocks_on(seq_state_e s);
        return (s == ST_DUMMY) || (s == ST_RESET) || (s == ST_RREC1) ||
               (s == ST_RCYC)  || (s == ST_RREC2);
    endfunction

    // Phases that open with a reset strobe followed by a guard window
    function automatic logic strobe_phase(seq_state_e s);
        return (s == ST_RESET) || (s == ST_RREC1) || (s == ST_RREC2);
    endfunction

endpackage

// File: rtl/fmem_seq_timer.sv
module fmem_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (en) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/fmem_seq_flag.sv
module fmem_seq_flag (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end
    end
endmodule

// File: rtl/fmem_seq_drive.sv
module fmem_seq_drive
    import fmem_init_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  seq_state_e       state,
    input  logic             first_cyc,
    output logic             wclk_en,
    output logic             rclk_en,
    output logic [NPORT-1:0] wrst,
    output logic [NPORT-1:0] rrst,
    output logic             done
);
    logic pulse;

    assign pulse   = strobe_phase(state) && first_cyc;
    assign wclk_en = clocks_on(state);
    assign rclk_en = clocks_on(state);
    assign done    = (state == ST_DONE);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign wrst[p] = pulse;
        assign rrst[p] = pulse;
    end
endmodule

// File: rtl/fmem_init_seq.sv
module fmem_init_seq
    import fmem_init_pkg::*;
#(
    parameter int NPORT      = 2,
    parameter int STABLE_CYC = 25000,
    parameter int DUMMY_CYC  = 80,
    parameter int RST_GAP    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             supply_ok,
    output logic             mem_wclk_en,
    output logic             mem_rclk_en,
    output logic [NPORT-1:0] mem_wrst,
    output logic [NPORT-1:0] mem_rrst,
    output logic             done
);
    localparam int CMAX = imax(imax(STABLE_CYC, DUMMY_CYC), RST_GAP + 1);
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] WAIT_LAST  = CW'(STABLE_CYC - 1);
    localparam logic [CW-1:0] DUMMY_LAST = CW'(DUMMY_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST   = CW'(RST_GAP);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt;
    logic          t_clr, t_en;
    logic          drop_seen, drop_now, go_recover;

    assign drop_now   = !supply_ok && ((state_q == ST_DUMMY) || (state_q == ST_RESET));
    assign go_recover = drop_seen || drop_now;

    fmem_seq_timer #(.W(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (t_clr),
        .en    (t_en),
        .count (cnt)
    );

    fmem_seq_flag u_flag (
        .clk (clk),
        .rst (rst),
        .clr (start),
        .set (drop_now),
        .q   (drop_seen)
    );

    always_comb begin
        state_d = state_q;
        t_clr   = 1'b0;
        t_en    = 1'b0;
        case (state_q)
            ST_IDLE: ;
            ST_WAIT: begin
                if (!supply_ok) begin
                    t_clr = 1'b1;
                end else if (cnt == WAIT_LAST) begin
                    state_d = ST_DUMMY;
                    t_clr   = 1'b1;
                end else begin
                    t_en = 1'b1;
                end
            end
            ST_DUMMY, ST_RCYC: begin
                if (cnt == DUMMY_LAST) begin
                    state_d = (state_q == ST_DUMMY) ? ST_RESET : ST_RREC2;
                    t_clr   = 1'b1;
                end else begin
                    t_en = 1'b1;
                end
            end
            ST_RESET, ST_RREC1, ST_RREC2: begin
                if (cnt == GAP_LAST) begin
                    t_clr = 1'b1;
                    if (state_q == ST_RESET) begin
                        state_d = go_recover ? ST_RREC1 : ST_DONE;
                    end else if (state_q == ST_RREC1) begin
                        state_d = ST_RCYC;
                    end else begin
                        state_d = ST_DONE;
                    end
                end else begin
                    t_en = 1'b1;
                end
            end
            ST_DONE: ;
            default: state_d = ST_IDLE;
        endcase
        if (start) begin
            state_d = ST_WAIT;
            t_clr   = 1'b1;
            t_en    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    fmem_seq_drive #(.NPORT(NPORT)) u_drive (
        .state     (state_q),
        .first_cyc (cnt == '0),
        .wclk_en   (mem_wclk_en),
        .rclk_en   (mem_rclk_en),
        .wrst      (mem_wrst),
        .rrst      (mem_rrst),
        .done      (done)
    );
endmodule

// File: rtl/fmem_init_seq_chk.sv
module fmem_init_seq_chk #(
    parameter int NPORT     = 2,
    parameter int DUMMY_CYC = 80
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             mem_wclk_en,
    input logic             mem_rclk_en,
    input logic [NPORT-1:0] mem_wrst,
    input logic [NPORT-1:0] mem_rrst,
    input logic             done
);
    localparam int RW = $clog2(DUMMY_CYC + 1) + 1;

    logic [RW-1:0] run;
    logic          pend;

    // Clock-enabled cycles since the gates opened; pend marks that no strobe followed yet
    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= '0;
            pend <= 1'b1;
        end else if (!mem_wclk_en) begin
            run  <= '0;
            pend <= 1'b1;
        end else begin
            if (run != {RW{1'b1}}) run <= run + 1'b1;
            if (mem_wrst[0]) pend <= 1'b0;
        end
    end

    // R4: first strobe after the gates open follows the full dummy run
    a_r4_dummy_before_strobe: assert property (@(posedge clk) disable iff (rst)
        (mem_wrst[0] && pend) |-> (run >= RW'(DUMMY_CYC)));

    // R5: all strobes fire together, with the clocks running
    a_r5_strobes_together: assert property (@(posedge clk) disable iff (rst)
        (mem_wrst[0] || mem_rrst[0]) |->
            (mem_wrst == {NPORT{1'b1}} && mem_rrst == {NPORT{1'b1}} && mem_wclk_en && mem_rclk_en));

    // R6: no strobe in the two cycles after a strobe
    a_r6_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
        mem_wrst[0] |=> (!mem_wrst[0] && !mem_rrst[0]));
    a_r6_strobe_spacing2: assert property (@(posedge clk) disable iff (rst)
        ($past(mem_wrst[0]) && !start) |=> !mem_wrst[0]);

    // R7: done persists until a restart
    a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9: restart drops done and the gates
    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !mem_wclk_en && !mem_rclk_en));

    // R10: done is quiet
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_wclk_en && !mem_rclk_en && mem_wrst == '0 && mem_rrst == '0));
endmodule

bind fmem_init_seq fmem_init_seq_chk #(.NPORT(NPORT), .DUMMY_CYC(DUMMY_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mem_wclk_en (mem_wclk_en),
    .mem_rclk_en (mem_rclk_en),
    .mem_wrst    (mem_wrst),
    .mem_rrst    (mem_rrst),
    .done        (done)
);

// File: tb/tb_fmem_init_seq.sv
module tb_fmem_init_seq;
    localparam int NP = 2;
    localparam int S  = 12;
    localparam int D  = 8;
    localparam int G  = 2;

    // Expected word: {done, wclk_en, rclk_en, wrst[1:0], rrst[1:0]}
    localparam logic [6:0] V_IDLE = 7'b0000000;
    localparam logic [6:0] V_CLK  = 7'b0110000;
    localparam logic [6:0] V_RST  = 7'b0111111;
    localparam logic [6:0] V_DONE = 7'b1000000;

    logic clk = 1'b0;
    logic rst, start, supply_ok;
    logic wclk_en, rclk_en, done;
    logic [NP-1:0] wrst, rrst;

    logic [6:0] expq[$];
    string      tagq[$];
    int n_run  = 0;
    int n_fail = 0;
    bit fin    = 1'b0;

    always #2 clk = ~clk;

    fmem_init_seq #(.NPORT(NP), .STABLE_CYC(S), .DUMMY_CYC(D), .RST_GAP(G)) dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .supply_ok   (supply_ok),
        .mem_wclk_en (wclk_en),
        .mem_rclk_en (rclk_en),
        .mem_wrst    (wrst),
        .mem_rrst    (rrst),
        .done        (done)
    );

    task automatic push(int n, logic [6:0] v, string tag);
        repeat (n) begin
            expq.push_back(v);
            tagq.push_back(tag);
        end
    endtask

    // Strobe plus guard window
    task automatic push_strobe(string tag);
        push(1, V_RST, {tag, " R5 strobe"});
        push(G, V_CLK, {tag, " R6 guard"});
    endtask

    task automatic drain();
        while (expq.size() > 0) @(negedge clk);
    endtask

    // Monitor: compares one expected word per cycle, shortly after the edge
    always @(posedge clk) begin
        #1;
        if (expq.size() > 0) begin
            logic [6:0] act, ex;
            string t;
            act = {done, wclk_en, rclk_en, wrst, rrst};
            ex  = expq.pop_front();
            t   = tagq.pop_front();
            n_run++;
            if (act !== ex) begin
                n_fail++;
                $display("FAIL %s: got %b expected %b", t, act, ex);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!fin) begin
            n_fail++;
            $display("FAIL R7 watchdog: done=%b expected 1", done);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: idle after reset, supply toggling has no effect
        push(4, V_IDLE, "R1 idle");
        supply_ok = 1'b1;
        @(negedge clk) supply_ok = 1'b0;
        @(negedge clk) supply_ok = 1'b1;
        drain();

        // Normal bring-up: R2 wait, R4 dummy, R5/R6 strobe, R7 done
        @(negedge clk);
        push(S, V_IDLE, "R2 wait");
        push(D, V_CLK, "R4 dummy");
        push_strobe("normal");
        push(4, V_DONE, "R7 done");
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        drain();
        push(3, V_DONE, "R7 done holds");
        drain();

        // R3: supply drop in the wait phase; restart from done (R9)
        @(negedge clk);
        push(1, V_IDLE, "R9 restart from done");
        push(3 + S, V_IDLE, "R3 wait restart");
        push(D, V_CLK, "R4 dummy");
        push_strobe("R3 path");
        push(2, V_DONE, "R7 done");
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk) supply_ok = 1'b1;
        drain();

        // R8: supply drop during the dummy phase forces a recovery pass
        @(negedge clk);
        push(S, V_IDLE, "R2 wait");
        push(D, V_CLK, "R4 dummy");
        push_strobe("R8 first");
        push_strobe("R8 recovery first");
        push(D, V_CLK, "R8 recovery cycles");
        push_strobe("R8 recovery second");
        push(3, V_DONE, "R8 done after recovery");
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (S + 1) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk) supply_ok = 1'b1;
        drain();

        // R9: drop recorded, then a restart mid-dummy clears it
        @(negedge clk);
        push(S, V_IDLE, "R2 wait");
        push(4, V_CLK, "R4 dummy before restart");
        push(S, V_IDLE, "R9 restart mid-dummy");
        push(D, V_CLK, "R4 dummy");
        push_strobe("R9 flag cleared");
        push(3, V_DONE, "R9 no recovery after restart");
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (S + 1) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk) supply_ok = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        drain();

        fin = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule